// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a set of device interrupt lines and a CPU. It watches eight level-sensitive request lines and one edge-triggered nonmaskable line. Each request line has its own mask bit. A fixed priority picks the one source to present: line 0 is the most urgent and line 7 the least. The controller raises one request to the CPU and gives a vector number with it. The CPU checks that request between instructions and, when it takes the interrupt, pulses an acknowledge.

On acknowledge, a maskable source is recorded as in service. While it is in service, only strictly more urgent lines can interrupt it, so handlers nest by priority. When a handler finishes it pulses end-of-interrupt. That clears the most urgent source still in service. Maskable sources map to a programmable window of vectors, base+0 to base+7. The base can never overlap the 32 slots reserved for CPU exceptions. The nonmaskable line always uses vector 2 and beats everything else.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, `cpu_irq` is 0 and `cpu_vec` is 0. All eight mask bits are set, so no line is presented until it is unmasked. The vector base is 32.
- R2: A masked line never raises `cpu_irq`. A line that is still held high when its mask bit is cleared is presented at that point (the request is deferred, not lost). Mask bit i (mask_din[i]=1 means masked) belongs to line i.
- R3: Among the unmasked, high, eligible lines, the one with the lowest index is presented. Its vector is base + index.
- R4: A line is eligible only if its index is strictly lower than the index of every source now in service. Lines of equal or lower priority wait.
- R5: An acknowledge taken while `cpu_irq` is 1 marks the presented maskable source as in service, and `cpu_irq` is 0 in the next cycle. An acknowledge while `cpu_irq` is 0 changes nothing.
- R6: An `eoi` pulse clears only the in-service bit with the lowest index. Any less urgent sources that are also in service stay in service.
- R7: A rising edge on `nmi_in` presents vector 2, whatever the mask, the request lines and the in-service state. It stays presented until it is acknowledged. It is never placed in service, and holding `nmi_in` high does not request it again.
- R8: A write of the vector base takes effect only for values from 32 to 248. Any other value is dropped and the previous base is kept.
- R9: Whenever `cpu_irq` is 0, `cpu_vec` is 0.
- R10: When nothing is in service, a change on an unmasked line shows on `cpu_irq`/`cpu_vec` after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_lines | input | 8 | Level-sensitive device request lines, index 0 most urgent |
| nmi_in | input | 1 | Nonmaskable request, rising-edge triggered |
| mask_wr | input | 1 | Load `mask_din` into the mask register |
| mask_din | input | 8 | New mask, 1 = line masked |
| base_wr | input | 1 | Load `base_din` as the vector base if it is in range |
| base_din | input | 8 | New vector base |
| cpu_ack | input | 1 | CPU acknowledge pulse |
| eoi | input | 1 | End-of-interrupt pulse from the handler |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| cpu_vec | output | 8 | Vector of the presented source, 0 when idle |

## Verification
The bench builds the block with its default parameters: eight lines, 8-bit vectors, a minimum base of 32 and vector 2 for the nonmaskable source. This configuration is small enough to sweep completely. The bench tries all 256 request patterns with no mask, all 256 mask values against fully asserted lines, and all 256 request patterns under each of the eight single in-service levels. It also writes every one of the 256 base values, so both edges of the accepted base window are covered. Nested acknowledge and end-of-interrupt sequences, stray acknowledges and nonmaskable arrivals during service are run as directed sequences.

// File: rtl/vic_pkg.sv
package vic_pkg;

  // Kind of source currently presented to the CPU.
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_NMI  = 2'd1,
    SRC_LINE = 2'd2
  } src_kind_e;

  // Vector slots held back for CPU exceptions.
  localparam int unsigned EXC_SLOTS = 32;

endpackage

// File: rtl/vic_rst_sync.sv
module vic_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  // Assert at once, release after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/vic_ffs.sv
module vic_ffs #(
  parameter int unsigned W  = 8,
  parameter int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);

  // Lowest set index wins.
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/vic_cfg.sv
module vic_cfg #(
  parameter int unsigned N_LINES  = 8,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned MIN_BASE = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mask_wr,
  input  logic [N_LINES-1:0] mask_din,
  input  logic               base_wr,
  input  logic [VEC_W-1:0]   base_din,
  output logic [N_LINES-1:0] mask_q,
  output logic [VEC_W-1:0]   base_q
);

  localparam logic [VEC_W-1:0] MIN_B = VEC_W'(MIN_BASE);
  localparam logic [VEC_W-1:0] MAX_B = VEC_W'((1 << VEC_W) - N_LINES);

  logic               base_ok;
  logic               mask_en;
  logic               base_en;
  logic [N_LINES-1:0] mask_d;
  logic [VEC_W-1:0]   base_d;

  always_comb begin
    base_ok = (base_din >= MIN_B) && (base_din <= MAX_B);
    mask_en = mask_wr;
    base_en = base_wr && base_ok;
    mask_d  = mask_din;
    base_d  = base_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      base_q <= MIN_B;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (base_en) base_q <= base_d;
    end
  end

  // R8
  base_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base_q >= MIN_B) && (base_q <= MAX_B));

  // R8
  base_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base_wr && ((base_din < MIN_B) || (base_din > MAX_B))) |=> $stable(base_q));

endmodule

// File: rtl/vic_isr.sv
module vic_isr #(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned IW      = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [IW-1:0]      set_idx,
  input  logic               eoi,
  output logic [N_LINES-1:0] isr_q,
  output logic [N_LINES-1:0] allow
);

  logic               top_found;
  logic [IW-1:0]      top_idx;
  logic [N_LINES-1:0] top_bit;
  logic [N_LINES-1:0] set_bit;
  logic [N_LINES-1:0] isr_d;
  logic               isr_en;

  vic_ffs #(.W(N_LINES), .IW(IW)) u_top (
    .vec   (isr_q),
    .found (top_found),
    .idx   (top_idx)
  );

  always_comb begin
    top_bit = N_LINES'(1) << top_idx;
    set_bit = N_LINES'(1) << set_idx;
    // Only strictly more urgent lines than the top in-service one may interrupt.
    allow   = top_found ? (top_bit - N_LINES'(1)) : '1;
    isr_en  = set_en || (eoi && top_found);
    isr_d   = isr_q;
    if (eoi && top_found) isr_d = isr_d & ~top_bit;
    if (set_en)           isr_d = isr_d | set_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      isr_q <= '0;
    else if (isr_en) isr_q <= isr_d;
  end

  // R6
  eoi_single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !set_en && (isr_q != '0)) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));

  // R6
  eoi_keeps_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !set_en) |=> ((isr_q & ~$past(isr_q)) == '0));

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int unsigned N_LINES  = 8,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned MIN_BASE = vic_pkg::EXC_SLOTS,
  parameter int unsigned NMI_VEC  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_lines,
  input  logic               nmi_in,
  input  logic               mask_wr,
  input  logic [N_LINES-1:0] mask_din,
  input  logic               base_wr,
  input  logic [VEC_W-1:0]   base_din,
  input  logic               cpu_ack,
  input  logic               eoi,
  output logic               cpu_irq,
  output logic [VEC_W-1:0]   cpu_vec
);

  import vic_pkg::*;

  localparam int unsigned     IW    = (N_LINES > 1) ? $clog2(N_LINES) : 1;
  localparam logic [VEC_W-1:0] NMI_V = VEC_W'(NMI_VEC);
  localparam logic [VEC_W-1:0] MIN_B = VEC_W'(MIN_BASE);

  logic               rst_n_i;
  logic [N_LINES-1:0] mask_q;
  logic [VEC_W-1:0]   base_q;
  logic [N_LINES-1:0] isr_q;
  logic [N_LINES-1:0] allow;
  logic [N_LINES-1:0] eligible;
  logic               elig_found;
  logic [IW-1:0]      elig_idx;

  logic               nmi_prev_q;
  logic               nmi_pend_q;
  logic               nmi_pend_d;
  logic               nmi_rise;
  logic               nmi_live;

  src_kind_e          kind_q, kind_d;
  logic [IW-1:0]      idx_q, idx_d;
  logic [VEC_W-1:0]   vec_q, vec_d;
  logic               take;
  logic               take_line;
  logic               take_nmi;

  vic_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  vic_cfg #(.N_LINES(N_LINES), .VEC_W(VEC_W), .MIN_BASE(MIN_BASE)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .mask_wr  (mask_wr),
    .mask_din (mask_din),
    .base_wr  (base_wr),
    .base_din (base_din),
    .mask_q   (mask_q),
    .base_q   (base_q)
  );

  vic_isr #(.N_LINES(N_LINES), .IW(IW)) u_isr (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .set_en  (take_line),
    .set_idx (idx_q),
    .eoi     (eoi),
    .isr_q   (isr_q),
    .allow   (allow)
  );

  assign eligible = irq_lines & ~mask_q & allow;

  vic_ffs #(.W(N_LINES), .IW(IW)) u_pick (
    .vec   (eligible),
    .found (elig_found),
    .idx   (elig_idx)
  );

  // Next-state logic.
  always_comb begin
    nmi_rise  = nmi_in && !nmi_prev_q;
    nmi_live  = nmi_pend_q || nmi_rise;
    take      = cpu_ack && (kind_q != SRC_NONE);
    take_line = take && (kind_q == SRC_LINE);
    take_nmi  = take && (kind_q == SRC_NMI);

    nmi_pend_d = take_nmi ? nmi_rise : nmi_live;

    kind_d = SRC_NONE;
    idx_d  = '0;
    vec_d  = '0;
    if (take) begin
      kind_d = SRC_NONE;
    end else if (nmi_live) begin
      kind_d = SRC_NMI;
      vec_d  = NMI_V;
    end else if (elig_found) begin
      kind_d = SRC_LINE;
      idx_d  = elig_idx;
      vec_d  = base_q + VEC_W'(elig_idx);
    end
  end

  // Register stage.
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      nmi_prev_q <= 1'b0;
      nmi_pend_q <= 1'b0;
      kind_q     <= SRC_NONE;
      idx_q      <= '0;
      vec_q      <= '0;
    end else begin
      nmi_prev_q <= nmi_in;
      nmi_pend_q <= nmi_pend_d;
      kind_q     <= kind_d;
      idx_q      <= idx_d;
      vec_q      <= vec_d;
    end
  end

  assign cpu_irq = (kind_q != SRC_NONE);
  assign cpu_vec = vec_q;

  // R5
  ack_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (cpu_ack && cpu_irq) |=> !cpu_irq);

  // R4
  nest_order_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (kind_q == SRC_LINE) |-> allow[idx_q]);

  // R7
  nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (nmi_rise && !cpu_ack) |=> (cpu_irq && (cpu_vec == NMI_V)));

  // R9
  idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !cpu_irq |-> (cpu_vec == '0));

  // R3
  line_window_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (kind_q == SRC_LINE) |-> (cpu_vec >= MIN_B));

endmodule

// File: tb/vec_irq_ctrl_test.sv
`timescale 1ns/1ps
module vec_irq_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_lines;
  logic       nmi_in;
  logic       mask_wr;
  logic [7:0] mask_din;
  logic       base_wr;
  logic [7:0] base_din;
  logic       cpu_ack;
  logic       eoi;
  logic       cpu_irq;
  logic [7:0] cpu_vec;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  vec_irq_ctrl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .nmi_in    (nmi_in),
    .mask_wr   (mask_wr),
    .mask_din  (mask_din),
    .base_wr   (base_wr),
    .base_din  (base_din),
    .cpu_ack   (cpu_ack),
    .eoi       (eoi),
    .cpu_irq   (cpu_irq),
    .cpu_vec   (cpu_vec)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int lowest(input int v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  // ev < 0: expect no request and a zero vector.
  task automatic expect_vec(input string tag, input int ev);
    int act;
    act = cpu_irq ? int'(cpu_vec) : (cpu_vec == 8'd0 ? -1 : 1000 + int'(cpu_vec));
    n_run++;
    if (act != ev) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, ev);
    end
  endtask

  task automatic write_mask(input logic [7:0] m);
    mask_wr = 1'b1; mask_din = m; step(1); mask_wr = 1'b0;
  endtask

  task automatic write_base(input logic [7:0] b);
    base_wr = 1'b1; base_din = b; step(1); base_wr = 1'b0;
  endtask

  // Acknowledge and check the request drops in the next cycle (R5).
  task automatic ack(input string tag);
    cpu_ack = 1'b1; step(1); cpu_ack = 1'b0;
    expect_vec(tag, -1);
  endtask

  task automatic pulse_eoi;
    eoi = 1'b1; step(1); eoi = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int cur_base;
    int e;
    rst_n = 1'b0; irq_lines = '0; nmi_in = 1'b0; mask_wr = 1'b0; mask_din = '0;
    base_wr = 1'b0; base_din = '0; cpu_ack = 1'b0; eoi = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);

    // R1: idle after reset, all lines masked
    expect_vec("R1 reset", -1);
    irq_lines = 8'hFF; step(3);
    expect_vec("R1 masked at reset", -1);

    // R2: full mask sweep, all lines high
    for (int m = 0; m < 256; m++) begin
      write_mask(8'(m)); step(2);
      e = lowest(~m & 8'hFF);
      expect_vec("R2 mask sweep", e < 0 ? -1 : 32 + e);
    end

    // R2: deferred line shows once unmasked
    irq_lines = 8'h08; write_mask(8'h08); step(2);
    expect_vec("R2 deferred held", -1);
    write_mask(8'h00); step(2);
    expect_vec("R2 deferred released", 35);

    // R3, R10, R9: every request pattern, one edge latency
    for (int p = 0; p < 256; p++) begin
      irq_lines = 8'(p); step(1);
      e = lowest(p);
      expect_vec("R3 R10 pattern", e < 0 ? -1 : 32 + e);
    end

    // R4: each single in-service level against all patterns
    for (int k = 0; k < 8; k++) begin
      irq_lines = '0; step(2);
      irq_lines = 8'(1 << k); step(1);
      expect_vec("R4 level present", 32 + k);
      ack("R5 ack drop");
      for (int p = 0; p < 256; p++) begin
        irq_lines = 8'(p); step(1);
        e = lowest(p & ((1 << k) - 1));
        expect_vec("R4 nested", e < 0 ? -1 : 32 + e);
      end
      irq_lines = '0; pulse_eoi(); step(1);
      expect_vec("R6 eoi idle", -1);
    end

    // R6: two nested levels
    irq_lines = 8'h20; step(1); expect_vec("R6 line5", 37); ack("R5 ack5");
    irq_lines = 8'h24; step(1); expect_vec("R6 line2 preempts", 34); ack("R5 ack2");
    irq_lines = 8'h48; step(2); expect_vec("R6 line3 blocked by 2", -1);
    pulse_eoi(); step(1); expect_vec("R6 eoi clears 2 only", 35);
    ack("R5 ack3");
    pulse_eoi(); step(1); expect_vec("R6 eoi clears 3 keeps 5", 35);
    irq_lines = 8'h40; step(2); expect_vec("R6 line6 blocked by 5", -1);
    pulse_eoi(); step(1); expect_vec("R6 eoi clears 5", 38);
    ack("R5 ack6"); irq_lines = '0; pulse_eoi(); step(2);

    // R5: stray acknowledge changes nothing
    expect_vec("R5 idle", -1);
    cpu_ack = 1'b1; step(1); cpu_ack = 1'b0; step(1);
    irq_lines = 8'h80; step(1);
    expect_vec("R5 stray ack ignored", 39);
    ack("R5 ack7"); irq_lines = '0; pulse_eoi(); step(2);

    // R7: nonmaskable beats masked lines, no repeat while held
    irq_lines = 8'hFF; write_mask(8'hFF); step(1);
    nmi_in = 1'b1; step(1);
    expect_vec("R7 nmi vector", 2);
    step(2); expect_vec("R7 nmi held until ack", 2);
    ack("R7 nmi ack");
    step(3); expect_vec("R7 no repeat while high", -1);
    nmi_in = 1'b0; step(1);

    // R7: nonmaskable over in-service line, not placed in service
    write_mask(8'h00); irq_lines = 8'h01; step(2);
    expect_vec("R7 line0", 32); ack("R5 ack0");
    irq_lines = 8'hFF; nmi_in = 1'b1; step(1);
    expect_vec("R7 nmi over service", 2);
    ack("R7 nmi ack2");
    step(2); expect_vec("R7 line0 still blocks", -1);
    pulse_eoi(); step(1); expect_vec("R7 nmi not in service", 32);
    ack("R5 ack0b"); irq_lines = '0; nmi_in = 1'b0; pulse_eoi(); step(2);

    // R8: every base value, line 7 alone unmasked
    write_mask(8'h7F); irq_lines = 8'h80; cur_base = 32;
    for (int b = 0; b < 256; b++) begin
      write_base(8'(b)); step(2);
      if (b >= 32 && b <= 248) cur_base = b;
      expect_vec("R8 base sweep", cur_base + 7);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule